// File: doc/BRIEF.md
# Multi-Port Oldest-First Issue Selector

This block decides, in every cycle, which ready entries of a reservation station leave through each of several issue ports. The station's age order is kept in an age matrix that the block updates itself whenever an entry is written. From that order it finds the oldest ready entry, the one with no older ready entry. It steers that entry to a chosen victim port. The other ports are filled from the remaining ready entries in plain index order.

A station that feeds a non-pipelined unit through more than one port runs in a second mode. In that mode at most one entry issues per cycle: the oldest ready one. A ping-pong bit that flips on every clock picks the port it uses. This spreads work over the unit copies behind the ports. Grants are combinational from the registered age state, the per-entry ready bits and the per-port unit ready bits. They are presented as one one-hot vector per port.

Top module: `iss_issue_select`

## Requirements
- R1: After reset no entry is valid, so no port shows a grant whatever the ready inputs are.
- R2: In the spreading mode (`unpipelined`=0, or a single port) the victim port, if its unit is ready, is granted the oldest ready entry. That entry is the valid, ready entry with no valid, ready entry written before it.
- R3: The victim port is port 0 when `load_mode`=1 and port N_PORTS-1 when `load_mode`=0.
- R4: In the spreading mode, the other ports are taken in ascending port number. Each ready one is granted the lowest-numbered ready entry not already granted this cycle.
- R5: Each port's grant slice (`grant[p*N_ENTRIES +: N_ENTRIES]`, bit i = entry i) has at most one bit set, and no entry is granted to two ports in one cycle.
- R6: A port whose `port_rdy` bit is 0 receives no grant. If the victim port is not ready, its oldest entry is available to the other ports.
- R7: With `unpipelined`=1 and more than one port, at most one grant is made per cycle: the oldest ready entry, to port 0 when the ping-pong bit is 0 and to port N_PORTS-1 when it is 1. No grant is made if that port is not ready.
- R8: The ping-pong bit is 0 in the first cycle after reset and inverts on every clock edge after that.
- R9: An entry written with `enq_en` becomes younger than every entry valid at that time. An entry cleared through `free_mask` stops being valid and is never granted until it is written again.
- R10: `entry_rdy` bits of entries that are not valid have no effect on any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_en | input | 1 | Write a new entry this cycle |
| enq_idx | input | IW | Slot number of the new entry |
| free_mask | input | N_ENTRIES | Entries leaving the station this cycle |
| entry_rdy | input | N_ENTRIES | Operands ready, per entry |
| port_rdy | input | N_PORTS | Downstream unit of each port can accept |
| load_mode | input | 1 | 1: victim port is port 0; 0: last port |
| unpipelined | input | 1 | 1: single issue with ping-pong port choice |
| grant | output | N_PORTS*N_ENTRIES | One-hot grant vector per port |

## Verification
A corrupted age matrix shows up in the same cycle as the wrong entry on the victim port. It then persists until every entry involved is rewritten, so one write order checked with all entries ready exposes it at once. A ping-pong bit stuck or out of phase moves the single grant to the wrong port within two cycles of `unpipelined` being raised. A broken valid vector shows as a grant on a freed slot in the cycle after the free.

// File: rtl/iss_pkg.sv
// Shared types for the issue selector.
// Assumes nothing beyond a synthesizable two-valued mode encoding.
package iss_pkg;
    typedef enum logic {
        SEL_SPREAD   = 1'b0,   // oldest to victim, others by index
        SEL_PINGPONG = 1'b1    // one grant, port chosen by toggle bit
    } sel_mode_e;
endpackage

// File: rtl/iss_age_matrix.sv
// Valid vector and age matrix of the station.
// older_o[i*N+j] = 1 means entry j was written before entry i.
// Assumes enq_idx never names an entry that is still valid.
module iss_age_matrix #(
    parameter int N_ENTRIES = 8,
    localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_en,
    input  logic [IW-1:0]                 enq_idx,
    input  logic [N_ENTRIES-1:0]          free_mask,
    output logic [N_ENTRIES-1:0]          valid_o,
    output logic [N_ENTRIES*N_ENTRIES-1:0] older_o
);
    logic [N_ENTRIES-1:0] valid_q;
    logic [N_ENTRIES-1:0] older_q [N_ENTRIES];

    // Track which slots hold entries, and their relative age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < N_ENTRIES; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                valid_q[i] <= (valid_q[i] & ~free_mask[i]) |
                              (enq_en && (enq_idx == IW'(i)));
                if (enq_en) begin
                    if (enq_idx == IW'(i))
                        older_q[i] <= valid_q & ~(N_ENTRIES'(1) << i);
                    else
                        older_q[i][enq_idx] <= 1'b0;
                end
            end
        end
    end

    assign valid_o = valid_q;
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_flat
        assign older_o[g*N_ENTRIES +: N_ENTRIES] = older_q[g];
    end
endmodule

// File: rtl/iss_oldest_pick.sv
// Finds the oldest candidate: a candidate with no older candidate.
// Assumes the age matrix is a strict order over the valid entries.
module iss_oldest_pick #(
    parameter int N_ENTRIES = 8
) (
    input  logic [N_ENTRIES-1:0]           cand,
    input  logic [N_ENTRIES*N_ENTRIES-1:0] older,
    output logic [N_ENTRIES-1:0]           oldest
);
    // One row reduction per entry.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_row
        assign oldest[g] = cand[g] &
                           ~|(older[g*N_ENTRIES +: N_ENTRIES] & cand);
    end
endmodule

// File: rtl/iss_port_fill.sv
// Hands the lowest-numbered available entries to the enabled ports,
// port 0 first; each entry goes to at most one port.
// Assumes the caller removes its own victim port from port_en.
module iss_port_fill #(
    parameter int N_ENTRIES = 8,
    parameter int N_PORTS   = 2
) (
    input  logic [N_ENTRIES-1:0]         avail,
    input  logic [N_PORTS-1:0]           port_en,
    output logic [N_PORTS*N_ENTRIES-1:0] fill
);
    logic [N_ENTRIES-1:0] rem;
    logic [N_ENTRIES-1:0] take;

    // Chain of lowest-one pickers, one stage per port.
    always_comb begin
        rem  = avail;
        fill = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            take = '0;
            if (port_en[p]) take = rem & (~rem + N_ENTRIES'(1));
            fill[p*N_ENTRIES +: N_ENTRIES] = take;
            rem = rem & ~take;
        end
    end
endmodule

// File: rtl/iss_issue_select.sv
// Top of the issue selector: age tracking, oldest pick, victim steering,
// index-order fill of the other ports, and ping-pong single issue.
// Assumes entry_rdy is meaningful only for valid entries.
module iss_issue_select
    import iss_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int N_PORTS   = 2,
    localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_en,
    input  logic [IW-1:0]                enq_idx,
    input  logic [N_ENTRIES-1:0]         free_mask,
    input  logic [N_ENTRIES-1:0]         entry_rdy,
    input  logic [N_PORTS-1:0]           port_rdy,
    input  logic                         load_mode,
    input  logic                         unpipelined,
    output logic [N_PORTS*N_ENTRIES-1:0] grant
);
    localparam bit MULTI_PORT = (N_PORTS > 1);

    logic [N_ENTRIES-1:0]           valid_w;
    logic [N_ENTRIES*N_ENTRIES-1:0] older_w;
    logic [N_ENTRIES-1:0]           cand;
    logic [N_ENTRIES-1:0]           oldest;
    logic [N_ENTRIES-1:0]           vic_take;
    logic [N_PORTS*N_ENTRIES-1:0]   fill_w;
    logic [PW-1:0]                  victim;
    logic [PW-1:0]                  pp_port;
    logic                           pp_q;
    sel_mode_e                      mode;

    iss_age_matrix #(.N_ENTRIES(N_ENTRIES)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_en    (enq_en),
        .enq_idx   (enq_idx),
        .free_mask (free_mask),
        .valid_o   (valid_w),
        .older_o   (older_w)
    );

    assign cand = entry_rdy & valid_w;

    iss_oldest_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .cand   (cand),
        .older  (older_w),
        .oldest (oldest)
    );

    // Victim port and the ping-pong target port.
    assign victim  = load_mode ? '0 : PW'(N_PORTS - 1);
    assign pp_port = pp_q ? PW'(N_PORTS - 1) : '0;
    assign mode    = (MULTI_PORT && unpipelined) ? SEL_PINGPONG : SEL_SPREAD;
    assign vic_take = port_rdy[victim] ? oldest : '0;

    iss_port_fill #(.N_ENTRIES(N_ENTRIES), .N_PORTS(N_PORTS)) u_fill (
        .avail   (cand & ~vic_take),
        .port_en (port_rdy & ~(N_PORTS'(1) << victim)),
        .fill    (fill_w)
    );

    // Ping-pong bit: flips on every clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= 1'b0;
        else        pp_q <= ~pp_q;
    end

    // Assemble the per-port grants for the active mode.
    always_comb begin
        grant = '0;
        if (mode == SEL_PINGPONG) begin
            if (port_rdy[pp_port])
                grant[pp_port*N_ENTRIES +: N_ENTRIES] = oldest;
        end else begin
            for (int p = 0; p < N_PORTS; p++) begin
                if (PW'(p) == victim)
                    grant[p*N_ENTRIES +: N_ENTRIES] = vic_take;
                else
                    grant[p*N_ENTRIES +: N_ENTRIES] = fill_w[p*N_ENTRIES +: N_ENTRIES];
            end
        end
    end
endmodule

// File: rtl/iss_select_chk.sv
// Property checker for iss_issue_select, attached by bind.
// Assumes it observes the top's ports plus its valid vector and toggle bit.
module iss_select_chk #(
    parameter int N_ENTRIES = 8,
    parameter int N_PORTS   = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_ENTRIES-1:0]         entry_rdy,
    input logic [N_PORTS-1:0]           port_rdy,
    input logic                         unpipelined,
    input logic [N_ENTRIES-1:0]         valid,
    input logic                         pp,
    input logic [N_PORTS*N_ENTRIES-1:0] grant
);
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        // R5: at most one entry per port
        assert_port_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[p*N_ENTRIES +: N_ENTRIES]));
        // R6: a busy port gets nothing
        assert_busy_port_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !port_rdy[p] |-> (grant[p*N_ENTRIES +: N_ENTRIES] == '0));
        // R10: grants only go to valid, ready entries
        assert_grant_valid_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[p*N_ENTRIES +: N_ENTRIES] & ~(entry_rdy & valid)) == '0);
    end

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        logic [N_PORTS-1:0] col;
        for (genvar p = 0; p < N_PORTS; p++) begin : g_col
            assign col[p] = grant[p*N_ENTRIES + e];
        end
        // R5: one entry never goes to two ports
        assert_entry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end

    // R7: single issue in ping-pong mode
    assert_single_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unpipelined && N_PORTS > 1) |-> ($countones(grant) <= 1));

    // R8: toggle bit inverts every cycle out of reset
    assert_pp_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pp != $past(pp)));
endmodule

bind iss_issue_select iss_select_chk #(
    .N_ENTRIES(N_ENTRIES),
    .N_PORTS  (N_PORTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_rdy   (entry_rdy),
    .port_rdy    (port_rdy),
    .unpipelined (unpipelined),
    .valid       (valid_w),
    .pp          (pp_q),
    .grant       (grant)
);

// File: tb/iss_issue_select_tb.sv
// Directed bench for iss_issue_select with a sequence-number reference model.
module iss_issue_select_tb;
    localparam int N  = 8;
    localparam int P  = 2;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enq_en = 1'b0;
    logic [IW-1:0]  enq_idx = '0;
    logic [N-1:0]   free_mask = '0;
    logic [N-1:0]   entry_rdy = '0;
    logic [P-1:0]   port_rdy = '0;
    logic           load_mode = 1'b0;
    logic           unpipelined = 1'b0;
    logic [P*N-1:0] grant;

    int tests = 0;
    int fails = 0;

    // Reference state
    logic   m_valid [N];
    int     m_seq   [N];
    int     seq_ctr = 0;
    logic   pp_m = 1'b0;

    iss_issue_select #(.N_ENTRIES(N), .N_PORTS(P)) u_dut (
        .clk, .rst_n, .enq_en, .enq_idx, .free_mask, .entry_rdy,
        .port_rdy, .load_mode, .unpipelined, .grant
    );

    always #4 clk = ~clk;

    // Model of the toggle bit, from R8.
    always @(posedge clk) pp_m <= rst_n ? ~pp_m : 1'b0;

    task automatic expected(output logic [P*N-1:0] e);
        logic [N-1:0] cand, ob, take, rem;
        int best;
        int vic, tgt;
        e = '0; ob = '0; best = -1;
        for (int i = 0; i < N; i++) cand[i] = entry_rdy[i] & m_valid[i];
        for (int i = 0; i < N; i++)
            if (cand[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
        if (best >= 0) ob[best] = 1'b1;
        if (unpipelined && P > 1) begin
            tgt = pp_m ? P - 1 : 0;
            if (port_rdy[tgt]) e[tgt*N +: N] = ob;
        end else begin
            vic  = load_mode ? 0 : P - 1;
            take = port_rdy[vic] ? ob : '0;
            e[vic*N +: N] = take;
            rem = cand & ~take;
            for (int p = 0; p < P; p++) begin
                if (p != vic && port_rdy[p]) begin
                    for (int i = 0; i < N; i++) begin
                        if (rem[i]) begin
                            e[p*N + i] = 1'b1;
                            rem[i] = 1'b0;
                            break;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(string req);
        logic [P*N-1:0] e;
        #1;
        expected(e);
        tests++;
        if (grant !== e) begin
            fails++;
            $display("FAIL %s: grant=%h expected=%h", req, grant, e);
        end
    endtask

    task automatic enq(int idx);
        @(negedge clk);
        enq_en = 1'b1; enq_idx = IW'(idx);
        @(posedge clk);
        m_valid[idx] = 1'b1; m_seq[idx] = seq_ctr; seq_ctr++;
        @(negedge clk);
        enq_en = 1'b0;
    endtask

    task automatic free(logic [N-1:0] m);
        @(negedge clk);
        free_mask = m;
        @(posedge clk);
        for (int i = 0; i < N; i++) if (m[i]) m_valid[i] = 1'b0;
        @(negedge clk);
        free_mask = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        entry_rdy = '1; port_rdy = '1;
        check("R1");
        tests++;
        if (grant !== '0) begin
            fails++;
            $display("FAIL R1: grant=%h expected=0", grant);
        end
    endtask

    task automatic t_victim_last;
        for (int k = 0; k < N; k++) enq((k * 5 + 5) % N);
        @(negedge clk);
        load_mode = 1'b0; unpipelined = 1'b0; entry_rdy = '1; port_rdy = '1;
        check("R2");
        tests++;   // oldest is entry 5 on port 1, port 0 takes entry 0 (R3, R4)
        if (grant !== {8'h20, 8'h01}) begin
            fails++;
            $display("FAIL R3: grant=%h expected=%h", grant, {8'h20, 8'h01});
        end
    endtask

    task automatic t_victim_first;
        @(negedge clk);
        load_mode = 1'b1; entry_rdy = 8'b1101_1110;
        check("R3");
        tests++;   // oldest ready is entry 2 on port 0, port 1 takes entry 1 (R4)
        if (grant !== {8'h02, 8'h04}) begin
            fails++;
            $display("FAIL R4: grant=%h expected=%h", grant, {8'h02, 8'h04});
        end
    endtask

    task automatic t_busy;
        @(negedge clk);
        load_mode = 1'b0; entry_rdy = '1; port_rdy = 2'b01;
        check("R6");   // victim busy: oldest free for port 0 only by index
        @(negedge clk);
        port_rdy = 2'b00;
        check("R6");
        @(negedge clk);
        port_rdy = 2'b10;
        check("R6");
    endtask

    task automatic t_free;
        free(8'b0010_0100);            // entries 5 and 2, the two oldest
        @(negedge clk);
        port_rdy = '1; load_mode = 1'b0; entry_rdy = 8'b0010_0100;
        check("R10");                  // only freed entries ready: no grant
        @(negedge clk);
        entry_rdy = '1;
        check("R9");
        enq(5);                        // rewritten: now the youngest
        @(negedge clk);
        entry_rdy = 8'b1010_0000;      // 7 older than new 5
        check("R9");
    endtask

    task automatic t_pingpong;
        @(negedge clk);
        unpipelined = 1'b1; port_rdy = '1; entry_rdy = '1;
        for (int k = 0; k < 6; k++) begin
            check("R7");
            @(negedge clk);
        end
        port_rdy = 2'b01;
        for (int k = 0; k < 4; k++) begin
            check("R8");
            @(negedge clk);
        end
        unpipelined = 1'b0;
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            entry_rdy   = N'($urandom);
            port_rdy    = P'($urandom);
            load_mode   = 1'($urandom);
            unpipelined = 1'($urandom);
            check("R5");
            if (k % 25 == 7) begin
                free(N'($urandom) & 8'h3c);
                for (int i = 0; i < N; i++) if (!m_valid[i]) enq(i);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_seq[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_victim_last();
        t_victim_first();
        t_busy();
        t_free();
        t_pingpong();
        t_random();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        tests++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule